// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block turns a set of pending interrupt requests into a single priority level and decides whether the core must take an interrupt trap. Two kinds of request feed it. The first is a software request word that firmware writes. The second is a vector of external interrupt lines, which the block samples on every clock. Software requests and external lines use different level encodings. Whenever any external line is pending, it outranks every software level.

The block holds the processor's current priority level in a 5-bit register. A trap is requested only when the resolved level is nonzero and strictly above that register. When the trap is issued, the block captures two values on the same edge: a bitmap of every pending request, and the level that won. The trap request then stays high until the consumer acknowledges it. A one-cycle pulse marks the edge where the trap was issued. After an acknowledge, the block resolves again against whatever priority level is current at that point.

Resolution is combinational from registered inputs. A request or a level change that is written at one clock edge therefore influences the trap decision at the following edge.

Top module: `irq_level_resolver`

## Requirements
- R1: During and directly after reset, trap_req, trap_pulse, irq_summary and irq_id are all zero, and the stored software word and priority level are zero.
- R2: A software write keeps only bits 4 through 18 of sw_wdata. Bits outside that field are dropped and never cause a trap.
- R3: A stored software bit at position i (4..18) stands for level i − 3, so software levels run from 1 to 15.
- R4: An external line at position i (20..31) stands for level i. External lines at positions 0..19 are ignored.
- R5: Among pending requests the highest level wins. Any pending external line outranks all software bits.
- R6: A trap issues only when the resolved level is nonzero and strictly greater than the current priority level. An equal level does not issue a trap.
- R7: On the issuing edge, irq_summary takes the OR of the stored software field and the sampled external field, and irq_id takes the winning level.
- R8: Once raised, trap_req stays high until trap_ack is seen. While it is held, irq_summary and irq_id do not change.
- R9: trap_pulse is high for exactly one cycle, on the same edge where trap_req rises.
- R10: With trap_req high, trap_ack drops trap_req at the next edge. A new trap can issue no earlier than the edge after that, and it is resolved against the priority level current at that time.
- R11: lvl_we loads the 5-bit priority level from lvl_wdata, and the new value governs the comparison from the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Load the software request word |
| sw_wdata | input | 32 | Software request word; only bits 4..18 are kept |
| lvl_we | input | 1 | Load the current priority level |
| lvl_wdata | input | 5 | New current priority level |
| ext_irq | input | 32 | External interrupt lines, sampled every cycle |
| trap_ack | input | 1 | Consumer acknowledges the outstanding trap |
| trap_req | output | 1 | Trap requested; held until acknowledged |
| trap_pulse | output | 1 | One-cycle marker of the issuing edge |
| irq_summary | output | 32 | Bitmap of all pending requests at issue |
| irq_id | output | 5 | Winning level at issue |

## Verification
The stored request word, the sampled external field and the priority level are all hidden. A fault in any of them shows up only when a trap issues. It appears at the ports as a wrong irq_id or irq_summary, or as a trap that comes one edge early, comes one edge late, or never comes. The bench therefore runs a cycle-level model next to the block and compares all four outputs at every cycle. A corrupted level or mask is caught at the first trap decision that depends on it, which is one or two edges after the write. Directed sequences pin down the cases where the mapping is most easily broken: the equal-level boundary, dropped field bits, and an external line overriding a higher software bit.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    localparam int SUM_W = 32;
    localparam int LVL_W = 5;

    typedef logic [SUM_W-1:0] sum_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    // Output of one highest-set-bit encoder
    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } enc_t;

    // Combined resolution result
    typedef struct packed {
        logic     any;
        lvl_t     lvl;
        sum_vec_t summary;
    } resolve_t;

    function automatic sum_vec_t span_mask(input int lo, input int hi);
        sum_vec_t m;
        m = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_lvl_pkg::*;
#(
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 31
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sw_we,
    input  sum_vec_t sw_wdata,
    input  logic     lvl_we,
    input  lvl_t     lvl_wdata,
    input  sum_vec_t ext_irq,
    output sum_vec_t sw_q,
    output sum_vec_t ext_q,
    output lvl_t     ipl_q
);

    localparam sum_vec_t SW_MASK  = span_mask(SW_LO, SW_HI);
    localparam sum_vec_t EXT_MASK = span_mask(EXT_LO, EXT_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q  <= '0;
            ext_q <= '0;
            ipl_q <= '0;
        end else begin
            if (sw_we)  sw_q  <= sw_wdata & SW_MASK;
            if (lvl_we) ipl_q <= lvl_wdata;
            ext_q <= ext_irq & EXT_MASK;
        end
    end

endmodule

// File: rtl/irq_hi_enc.sv
module irq_hi_enc
    import irq_lvl_pkg::*;
#(
    parameter int LO   = 4,
    parameter int HI   = 18,
    parameter int BIAS = 3
) (
    input  logic [HI-LO:0] req,
    output enc_t           enc
);

    // Ascending scan: the last set bit seen is the highest and wins
    always_comb begin
        enc = '0;
        for (int i = 0; i <= HI - LO; i++) begin
            if (req[i]) begin
                enc.hit = 1'b1;
                enc.lvl = LVL_W'(i + LO - BIAS);
            end
        end
    end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_lvl_pkg::*;
#(
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 31
) (
    input  sum_vec_t sw_q,
    input  sum_vec_t ext_q,
    output resolve_t res
);

    enc_t sw_enc;
    enc_t ext_enc;

    irq_hi_enc #(.LO(SW_LO), .HI(SW_HI), .BIAS(SW_LO - 1)) u_sw_enc (
        .req (sw_q[SW_HI:SW_LO]),
        .enc (sw_enc)
    );

    irq_hi_enc #(.LO(EXT_LO), .HI(EXT_HI), .BIAS(0)) u_ext_enc (
        .req (ext_q[EXT_HI:EXT_LO]),
        .enc (ext_enc)
    );

    always_comb begin
        res.summary = sw_q | ext_q;
        res.any     = sw_enc.hit | ext_enc.hit;
        res.lvl     = ext_enc.hit ? ext_enc.lvl : sw_enc.lvl;
    end

endmodule

// File: rtl/irq_trap_ctl.sv
module irq_trap_ctl
    import irq_lvl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  resolve_t res,
    input  lvl_t     ipl_q,
    input  logic     trap_ack,
    output logic     trap_req,
    output logic     trap_pulse,
    output sum_vec_t irq_summary,
    output lvl_t     irq_id
);

    logic issue;

    assign issue = !trap_req && res.any && (res.lvl != '0) && (res.lvl > ipl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_req    <= 1'b0;
            trap_pulse  <= 1'b0;
            irq_summary <= '0;
            irq_id      <= '0;
        end else begin
            trap_pulse <= issue;
            if (trap_req) begin
                if (trap_ack) trap_req <= 1'b0;
            end else if (issue) begin
                trap_req    <= 1'b1;
                irq_summary <= res.summary;
                irq_id      <= res.lvl;
            end
        end
    end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_lvl_pkg::*;
#(
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [SUM_W-1:0] sw_wdata,
    input  logic             lvl_we,
    input  logic [LVL_W-1:0] lvl_wdata,
    input  logic [SUM_W-1:0] ext_irq,
    input  logic             trap_ack,
    output logic             trap_req,
    output logic             trap_pulse,
    output logic [SUM_W-1:0] irq_summary,
    output logic [LVL_W-1:0] irq_id
);

    sum_vec_t sw_q;
    sum_vec_t ext_q;
    lvl_t     ipl_q;
    resolve_t res;

    irq_src_regs #(
        .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sw_we     (sw_we),
        .sw_wdata  (sw_wdata),
        .lvl_we    (lvl_we),
        .lvl_wdata (lvl_wdata),
        .ext_irq   (ext_irq),
        .sw_q      (sw_q),
        .ext_q     (ext_q),
        .ipl_q     (ipl_q)
    );

    irq_prio_sel #(
        .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_sel (
        .sw_q  (sw_q),
        .ext_q (ext_q),
        .res   (res)
    );

    irq_trap_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .res         (res),
        .ipl_q       (ipl_q),
        .trap_ack    (trap_ack),
        .trap_req    (trap_req),
        .trap_pulse  (trap_pulse),
        .irq_summary (irq_summary),
        .irq_id      (irq_id)
    );

endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
    import irq_lvl_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     trap_ack,
    input logic     trap_req,
    input logic     trap_pulse,
    input sum_vec_t irq_summary,
    input lvl_t     irq_id,
    input lvl_t     cur_lvl
);

    // R8: held request keeps its captured values until acknowledged
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        trap_req && !trap_ack |=> trap_req && $stable(irq_summary) && $stable(irq_id));

    // R9: the pulse marks the rising edge of the request
    a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_req) |-> trap_pulse);

    a_r9_pulse_only_rise: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> $rose(trap_req));

    // R6: the issued level is strictly above the level in force at the issuing edge
    a_r6_strict_above: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> irq_id > $past(cur_lvl));

    // R10: acknowledge drops the request at the next edge
    a_r10_ack_drops: assert property (@(posedge clk) disable iff (rst)
        trap_req && trap_ack |=> !trap_req);

    // R6: a held trap never carries level zero
    a_r6_id_nonzero: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> irq_id != '0);

endmodule

bind irq_level_resolver irq_level_resolver_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .trap_ack    (trap_ack),
    .trap_req    (trap_req),
    .trap_pulse  (trap_pulse),
    .irq_summary (irq_summary),
    .irq_id      (irq_id),
    .cur_lvl     (ipl_q)
);

// File: tb/irq_level_resolver_bench.sv
`timescale 1ns/1ps
module irq_level_resolver_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        lvl_we = 1'b0;
    logic [4:0]  lvl_wdata = '0;
    logic [31:0] ext_irq = '0;
    logic        trap_ack = 1'b0;
    logic        trap_req;
    logic        trap_pulse;
    logic [31:0] irq_summary;
    logic [4:0]  irq_id;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_level_resolver u_irq_level_resolver (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .ext_irq(ext_irq),
        .trap_ack(trap_ack), .trap_req(trap_req), .trap_pulse(trap_pulse),
        .irq_summary(irq_summary), .irq_id(irq_id)
    );

    localparam logic [31:0] SW_FIELD  = 32'h0007_FFF0; // bits 4..18 (R2)
    localparam logic [31:0] EXT_FIELD = 32'hFFF0_0000; // bits 20..31 (R4)

    // Expected level from the requirements: external high-to-low first, then software
    function automatic logic [4:0] want_lvl(input logic [31:0] sw, input logic [31:0] ext);
        for (int i = 31; i >= 20; i--) if (ext[i]) return 5'(i);
        for (int i = 18; i >= 4; i--) if (sw[i]) return 5'(i - 3);
        return 5'd0;
    endfunction

    // Cycle-level model built from R1..R11
    logic [31:0] m_sw, m_ext, m_sum;
    logic [4:0]  m_ipl, m_id;
    logic        m_req, m_pulse;

    always @(posedge clk) begin
        if (rst) begin
            m_sw <= '0; m_ext <= '0; m_ipl <= '0;
            m_req <= 1'b0; m_pulse <= 1'b0; m_sum <= '0; m_id <= '0;
        end else begin
            if (sw_we)  m_sw  <= sw_wdata & SW_FIELD;
            if (lvl_we) m_ipl <= lvl_wdata;
            m_ext   <= ext_irq & EXT_FIELD;
            m_pulse <= 1'b0;
            if (m_req) begin
                if (trap_ack) m_req <= 1'b0;
            end else if (want_lvl(m_sw, m_ext) != 0 && want_lvl(m_sw, m_ext) > m_ipl) begin
                m_req   <= 1'b1;
                m_pulse <= 1'b1;
                m_sum   <= m_sw | m_ext;
                m_id    <= want_lvl(m_sw, m_ext);
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_we();
        sw_we = 1'b0; lvl_we = 1'b0; trap_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        // R1: outputs are clear after reset
        chk("R1", "trap_req", 32'(trap_req), 0);
        chk("R1", "trap_pulse", 32'(trap_pulse), 0);
        chk("R1", "summary", irq_summary, 0);
        chk("R1", "id", 32'(irq_id), 0);

        // R2: bits 3 and 19 fall outside the software field
        lvl_we = 1; lvl_wdata = 0; sw_we = 1; sw_wdata = 32'h0008_0008;
        tick(); release_we(); tick();
        chk("R2", "trap_req", 32'(trap_req), 0);

        // R6: software bit 8 is level 5, equal to current level 5
        lvl_we = 1; lvl_wdata = 5; sw_we = 1; sw_wdata = 32'h0000_0100;
        tick(); release_we(); tick();
        chk("R6", "trap_req equal", 32'(trap_req), 0);

        // R11 / R3 / R7 / R9: lower the level to 4, then the trap issues
        lvl_we = 1; lvl_wdata = 4;
        tick(); release_we();
        chk("R11", "trap_req before effect", 32'(trap_req), 0);
        tick();
        chk("R3", "id", 32'(irq_id), 5);
        chk("R7", "summary", irq_summary, 32'h0000_0100);
        chk("R9", "pulse", 32'(trap_pulse), 1);

        // R8: request held, captured values stable despite a new software write
        sw_we = 1; sw_wdata = 32'h0004_0100;
        tick(); release_we();
        chk("R9", "pulse one cycle", 32'(trap_pulse), 0);
        chk("R8", "trap_req held", 32'(trap_req), 1);
        chk("R8", "summary stable", irq_summary, 32'h0000_0100);
        chk("R8", "id stable", 32'(irq_id), 5);

        // R10 / R5: acknowledge, then re-issue with the higher software bit 18
        trap_ack = 1;
        tick(); release_we();
        chk("R10", "trap_req after ack", 32'(trap_req), 0);
        tick();
        chk("R10", "reissue", 32'(trap_req), 1);
        chk("R5", "highest software", 32'(irq_id), 15);

        // R4 / R5: external line 20 outranks; line 5 is ignored
        ext_irq = 32'h0010_0020; trap_ack = 1;
        tick(); release_we();
        chk("R10", "trap_req after ack", 32'(trap_req), 0);
        tick();
        chk("R5", "external wins", 32'(irq_id), 20);
        chk("R4", "summary", irq_summary, 32'h0014_0100);

        // R6: level equal to 20 blocks, 19 allows
        lvl_we = 1; lvl_wdata = 20; trap_ack = 1;
        tick(); release_we(); tick();
        chk("R6", "equal external", 32'(trap_req), 0);
        lvl_we = 1; lvl_wdata = 19;
        tick(); release_we(); tick();
        chk("R6", "above by one", 32'(trap_req), 1);
        chk("R6", "id", 32'(irq_id), 20);

        // R11 / R4: level 31 blocks line 31; level 30 lets it through
        lvl_we = 1; lvl_wdata = 31; trap_ack = 1; ext_irq = 32'h8000_0000;
        tick(); release_we(); tick(); tick();
        chk("R11", "top level blocks", 32'(trap_req), 0);
        lvl_we = 1; lvl_wdata = 30;
        tick(); release_we(); tick();
        chk("R4", "line 31", 32'(irq_id), 31);
        chk("R7", "summary", irq_summary, 32'h8004_0100);

        // Clear and run random traffic against the model
        sw_we = 1; sw_wdata = 0; ext_irq = 0; lvl_we = 1; lvl_wdata = 0; trap_ack = 1;
        tick(); release_we(); tick();
        void'($urandom(32'd7331));
        for (int n = 0; n < 3000; n++) begin
            sw_we     = ($urandom % 8) == 0;
            sw_wdata  = $urandom & $urandom;
            lvl_we    = ($urandom % 8) == 0;
            lvl_wdata = 5'($urandom);
            if (($urandom % 4) == 0) ext_irq = $urandom & $urandom & $urandom;
            trap_ack  = ($urandom % 3) == 0;
            tick();
            chk("R8", "trap_req", 32'(trap_req), 32'(m_req));
            chk("R9", "trap_pulse", 32'(trap_pulse), 32'(m_pulse));
            chk("R7", "summary", irq_summary, m_sum);
            chk("R5", "id", 32'(irq_id), 32'(m_id));
        end
        release_we();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule